// File: doc/BRIEF.md
# System Control Register Bank with Interval Timer

This block holds the privileged control registers of a 32-bit processor core. It accepts move-to writes and move-from reads that name a register by a 5-bit number. Each write passes through a mask owned by the target register, so bits that are fixed in hardware stay fixed. Some writes also have side effects. Loading the wired-boundary register restarts the replacement pointer at the top entry. Loading the compare register drops the pending timer interrupt. The context register keeps every field except its top nine bits.

The block also has a free-running counter that advances on a tick-enable pulse. When an increment brings the counter equal to the compare value, a timer interrupt is latched into bit 15 of the cause register. A replacement pointer steps down once per retired instruction and never goes below the wired boundary. Reads are combinational and come back sign-extended to the core's 64-bit width. A one-cycle error pulse marks writes that are not allowed. The status value is also driven onto its own output for the rest of the core.

Top module: `sysctl_regbank`

## Requirements
- R1: A write stores the data ANDed with the target register's mask. Masks: Index(0) 0x8000003F, EntryLo0(2) and EntryLo1(3) 0x3FFFFFFF, PageMask(5) 0x01FFE000, EntryHi(10) 0xFFFFE0FF, TagLo(28) 0x0FFFFFC0. Status(12), EPC(14), Config(16), WatchLo(18) and WatchHi(19) keep all 32 bits.
- R2: An Index write whose bits 5:0 hold a value of 32 or more still stores its masked value, and it raises accessErr.
- R3: A Context(4) write replaces bits 31:23 only. Bits 22:4 keep their earlier contents, and bits 3:0 read as zero.
- R4: A Wired(6) write stores all 32 bits and sets Random(1) to 31 on the same edge.
- R5: Writes to Random(1), BadVAddr(8) and PrevID(15) change nothing and raise no error. A write to TagHi(29) always stores zero.
- R6: Count(9) increases by one on every clock edge where tickEn is high. A Count write loads the written value, takes priority over a tick in the same cycle, and counting continues from it. The counter wraps from 0xFFFFFFFF to 0.
- R7: When an increment makes Count equal to Compare(11), Cause(13) bit 15 is set. The bit stays set on later ticks, and timerIrq follows it. Writing Count to a value equal to Compare does not set it.
- R8: A Compare write stores all 32 bits and clears Cause bit 15.
- R9: A Cause write of zero clears Cause. A nonzero Cause write leaves Cause unchanged and raises accessErr.
- R10: A write to a register number other than 0-6, 8-16, 18, 19, 28 or 29 raises accessErr. accessErr is high for exactly the one cycle after an offending write, and low otherwise.
- R11: On each retirePulse, Random decrements by one. When Random is already at or below Wired, it reloads 31 instead.
- R12: rdData returns the addressed 32-bit register sign-extended to 64 bits. Unimplemented numbers read as zero.
- R13: After reset, every register reads zero except Random, which reads 31. statusOut always shows the Status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Move-to write request |
| regNum | input | 5 | Register number for read and write |
| wrData | input | 32 | Write data |
| tickEn | input | 1 | Counter increment pulse |
| retirePulse | input | 1 | Retired-instruction pulse for the replacement pointer |
| rdData | output | 64 | Sign-extended read data for regNum |
| accessErr | output | 1 | One-cycle pulse after an illegal write |
| statusOut | output | 32 | Current Status register |
| timerIrq | output | 1 | Pending timer interrupt (Cause bit 15) |

## Verification
Reads are combinational, so a wrong mask or a lost side effect shows on rdData as soon as the affected register is addressed after the write edge. A counter that ticks one step early or late shows on timerIrq at the increment that should have reached Compare, not later. A stale or sticky error flag shows on accessErr in the cycle straight after the write. A wrong decrement or wrap point in the replacement pointer shows after a short run of retire pulses that ends on the wired boundary.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W    = 32;
  localparam int REG_NUM_W = 5;
  localparam int TIMER_BIT = 15;

  localparam logic [REG_NUM_W-1:0] RN_INDEX    = 5'd0;
  localparam logic [REG_NUM_W-1:0] RN_RANDOM   = 5'd1;
  localparam logic [REG_NUM_W-1:0] RN_ENTRYLO0 = 5'd2;
  localparam logic [REG_NUM_W-1:0] RN_ENTRYLO1 = 5'd3;
  localparam logic [REG_NUM_W-1:0] RN_CONTEXT  = 5'd4;
  localparam logic [REG_NUM_W-1:0] RN_PAGEMASK = 5'd5;
  localparam logic [REG_NUM_W-1:0] RN_WIRED    = 5'd6;
  localparam logic [REG_NUM_W-1:0] RN_BADVADDR = 5'd8;
  localparam logic [REG_NUM_W-1:0] RN_COUNT    = 5'd9;
  localparam logic [REG_NUM_W-1:0] RN_ENTRYHI  = 5'd10;
  localparam logic [REG_NUM_W-1:0] RN_COMPARE  = 5'd11;
  localparam logic [REG_NUM_W-1:0] RN_STATUS   = 5'd12;
  localparam logic [REG_NUM_W-1:0] RN_CAUSE    = 5'd13;
  localparam logic [REG_NUM_W-1:0] RN_EPC      = 5'd14;
  localparam logic [REG_NUM_W-1:0] RN_PREVID   = 5'd15;
  localparam logic [REG_NUM_W-1:0] RN_CONFIG   = 5'd16;
  localparam logic [REG_NUM_W-1:0] RN_WATCHLO  = 5'd18;
  localparam logic [REG_NUM_W-1:0] RN_WATCHHI  = 5'd19;
  localparam logic [REG_NUM_W-1:0] RN_TAGLO    = 5'd28;
  localparam logic [REG_NUM_W-1:0] RN_TAGHI    = 5'd29;

  localparam logic [WORD_W-1:0] MASK_INDEX    = 32'h8000_003F;
  localparam logic [WORD_W-1:0] MASK_ENTRYLO  = 32'h3FFF_FFFF;
  localparam logic [WORD_W-1:0] MASK_PAGEMASK = 32'h01FF_E000;
  localparam logic [WORD_W-1:0] MASK_ENTRYHI  = 32'hFFFF_E0FF;
  localparam logic [WORD_W-1:0] MASK_TAGLO    = 32'h0FFF_FFC0;
  localparam int CTX_HI_LSB = 23;

  typedef struct packed {
    logic wrIndex;
    logic wrEntryLo0;
    logic wrEntryLo1;
    logic wrContext;
    logic wrPageMask;
    logic wrWired;
    logic wrCount;
    logic wrEntryHi;
    logic wrCompare;
    logic wrStatus;
    logic wrCause;
    logic wrEpc;
    logic wrConfig;
    logic wrWatchLo;
    logic wrWatchHi;
    logic wrTagLo;
    logic wrTagHi;
  } wrStrobe_t;
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int TLB_ENTRIES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_NUM_W-1:0] regNum,
  input  logic [WORD_W-1:0]    wrData,
  output wrStrobe_t            stb,
  output logic                 accessErr
);
  localparam logic [6:0] IDX_LIMIT = 7'(TLB_ENTRIES);

  logic badNow;

  always_comb begin
    stb    = '0;
    badNow = 1'b0;
    if (wrEn) begin
      case (regNum)
        RN_INDEX: begin
          stb.wrIndex = 1'b1;
          badNow = ({1'b0, wrData[5:0]} >= IDX_LIMIT);
        end
        RN_ENTRYLO0: stb.wrEntryLo0 = 1'b1;
        RN_ENTRYLO1: stb.wrEntryLo1 = 1'b1;
        RN_CONTEXT:  stb.wrContext  = 1'b1;
        RN_PAGEMASK: stb.wrPageMask = 1'b1;
        RN_WIRED:    stb.wrWired    = 1'b1;
        RN_COUNT:    stb.wrCount    = 1'b1;
        RN_ENTRYHI:  stb.wrEntryHi  = 1'b1;
        RN_COMPARE:  stb.wrCompare  = 1'b1;
        RN_STATUS:   stb.wrStatus   = 1'b1;
        RN_CAUSE: begin
          stb.wrCause = (wrData == '0);
          badNow = (wrData != '0);
        end
        RN_EPC:      stb.wrEpc      = 1'b1;
        RN_CONFIG:   stb.wrConfig   = 1'b1;
        RN_WATCHLO:  stb.wrWatchLo  = 1'b1;
        RN_WATCHHI:  stb.wrWatchHi  = 1'b1;
        RN_TAGLO:    stb.wrTagLo    = 1'b1;
        RN_TAGHI:    stb.wrTagHi    = 1'b1;
        RN_RANDOM, RN_BADVADDR, RN_PREVID: badNow = 1'b0;
        default:     badNow = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) accessErr <= 1'b0;
    else       accessErr <= badNow;
  end

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !wrEn) |=> !accessErr);

  // R9
  cause_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && wrEn && regNum == RN_CAUSE && wrData != '0) |=> accessErr);

  // R10
  unlisted_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && wrEn && (regNum == 5'd7 || regNum == 5'd17 || regNum == 5'd31)) |=> accessErr);
endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int TLB_ENTRIES = 32,
  parameter int OUT_W       = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            stb,
  input  logic [REG_NUM_W-1:0] regNum,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 tickEn,
  input  logic                 retirePulse,
  output logic [OUT_W-1:0]     rdData,
  output logic [WORD_W-1:0]    statusOut,
  output logic                 timerIrq
);
  localparam int RAND_W = $clog2(TLB_ENTRIES);
  localparam logic [RAND_W-1:0] RAND_TOP = RAND_W'(TLB_ENTRIES - 1);

  logic [WORD_W-1:0] indexReg, entryLo0Reg, entryLo1Reg, contextReg, pageMaskReg;
  logic [WORD_W-1:0] wiredReg, countReg, entryHiReg, compareReg, statusReg;
  logic [WORD_W-1:0] causeReg, epcReg, configReg, watchLoReg, watchHiReg;
  logic [WORD_W-1:0] tagLoReg, tagHiReg, badVAddrReg, prevIdReg;
  logic [RAND_W-1:0] randomReg;
  logic [WORD_W-1:0] countInc;
  logic              timerHit;
  logic              atBoundary;
  logic [WORD_W-1:0] rdWord;

  assign countInc   = countReg + 32'd1;
  assign timerHit   = tickEn && !stb.wrCount && (countInc == compareReg);
  assign atBoundary = (WORD_W'(randomReg) <= wiredReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg    <= '0;
      entryLo0Reg <= '0;
      entryLo1Reg <= '0;
      contextReg  <= '0;
      pageMaskReg <= '0;
      wiredReg    <= '0;
      entryHiReg  <= '0;
      compareReg  <= '0;
      statusReg   <= '0;
      epcReg      <= '0;
      configReg   <= '0;
      watchLoReg  <= '0;
      watchHiReg  <= '0;
      tagLoReg    <= '0;
      tagHiReg    <= '0;
      badVAddrReg <= '0;
      prevIdReg   <= '0;
    end else begin
      if (stb.wrIndex)    indexReg    <= wrData & MASK_INDEX;
      if (stb.wrEntryLo0) entryLo0Reg <= wrData & MASK_ENTRYLO;
      if (stb.wrEntryLo1) entryLo1Reg <= wrData & MASK_ENTRYLO;
      if (stb.wrContext)
        contextReg <= {wrData[WORD_W-1:CTX_HI_LSB], contextReg[CTX_HI_LSB-1:0]};
      if (stb.wrPageMask) pageMaskReg <= wrData & MASK_PAGEMASK;
      if (stb.wrWired)    wiredReg    <= wrData;
      if (stb.wrEntryHi)  entryHiReg  <= wrData & MASK_ENTRYHI;
      if (stb.wrCompare)  compareReg  <= wrData;
      if (stb.wrStatus)   statusReg   <= wrData;
      if (stb.wrEpc)      epcReg      <= wrData;
      if (stb.wrConfig)   configReg   <= wrData;
      if (stb.wrWatchLo)  watchLoReg  <= wrData;
      if (stb.wrWatchHi)  watchHiReg  <= wrData;
      if (stb.wrTagLo)    tagLoReg    <= wrData & MASK_TAGLO;
      if (stb.wrTagHi)    tagHiReg    <= '0;
    end
  end

  // Counter and timer interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      causeReg <= '0;
    end else begin
      if (stb.wrCount)  countReg <= wrData;
      else if (tickEn)  countReg <= countInc;
      if (stb.wrCause)        causeReg            <= '0;
      else if (stb.wrCompare) causeReg[TIMER_BIT] <= 1'b0;
      else if (timerHit)      causeReg[TIMER_BIT] <= 1'b1;
    end
  end

  // Replacement pointer
  always_ff @(posedge clk) begin
    if (!rstN)              randomReg <= RAND_TOP;
    else if (stb.wrWired)   randomReg <= RAND_TOP;
    else if (retirePulse)   randomReg <= atBoundary ? RAND_TOP : randomReg - 1'b1;
  end

  always_comb begin
    case (regNum)
      RN_INDEX:    rdWord = indexReg;
      RN_RANDOM:   rdWord = WORD_W'(randomReg);
      RN_ENTRYLO0: rdWord = entryLo0Reg;
      RN_ENTRYLO1: rdWord = entryLo1Reg;
      RN_CONTEXT:  rdWord = contextReg;
      RN_PAGEMASK: rdWord = pageMaskReg;
      RN_WIRED:    rdWord = wiredReg;
      RN_BADVADDR: rdWord = badVAddrReg;
      RN_COUNT:    rdWord = countReg;
      RN_ENTRYHI:  rdWord = entryHiReg;
      RN_COMPARE:  rdWord = compareReg;
      RN_STATUS:   rdWord = statusReg;
      RN_CAUSE:    rdWord = causeReg;
      RN_EPC:      rdWord = epcReg;
      RN_PREVID:   rdWord = prevIdReg;
      RN_CONFIG:   rdWord = configReg;
      RN_WATCHLO:  rdWord = watchLoReg;
      RN_WATCHHI:  rdWord = watchHiReg;
      RN_TAGLO:    rdWord = tagLoReg;
      RN_TAGHI:    rdWord = tagHiReg;
      default:     rdWord = '0;
    endcase
  end

  assign rdData    = {{(OUT_W-WORD_W){rdWord[WORD_W-1]}}, rdWord};
  assign statusOut = statusReg;
  assign timerIrq  = causeReg[TIMER_BIT];

  // R8
  compare_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && stb.wrCompare) |=> !timerIrq);

  // R4
  wired_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && stb.wrWired) |=> (randomReg == RAND_TOP));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && tickEn && !stb.wrCount) |=> (countReg == $past(countReg) + 32'd1));

  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && timerIrq && !stb.wrCompare && !stb.wrCause) |=> timerIrq);

  // R11
  random_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && retirePulse && !stb.wrWired && !atBoundary) |=>
      (randomReg == $past(randomReg) - 1'b1));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int TLB_ENTRIES = 32,
  parameter int OUT_W       = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_NUM_W-1:0] regNum,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 tickEn,
  input  logic                 retirePulse,
  output logic [OUT_W-1:0]     rdData,
  output logic                 accessErr,
  output logic [WORD_W-1:0]    statusOut,
  output logic                 timerIrq
);
  wrStrobe_t stb;

  sysctl_ctrl #(.TLB_ENTRIES(TLB_ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regNum(regNum),
    .wrData(wrData), .stb(stb), .accessErr(accessErr)
  );

  sysctl_dp #(.TLB_ENTRIES(TLB_ENTRIES), .OUT_W(OUT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regNum(regNum), .wrData(wrData),
    .tickEn(tickEn), .retirePulse(retirePulse), .rdData(rdData),
    .statusOut(statusOut), .timerIrq(timerIrq)
  );
endmodule

// File: tb/sysctl_regbank_tb_top.sv
`timescale 1ns/1ps
module sysctl_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  regNum = '0;
  logic [31:0] wrData = '0;
  logic        tickEn = 1'b0;
  logic        retirePulse = 1'b0;
  logic [63:0] rdData;
  logic        accessErr;
  logic [31:0] statusOut;
  logic        timerIrq;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sysctl_regbank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regNum(regNum), .wrData(wrData),
    .tickEn(tickEn), .retirePulse(retirePulse), .rdData(rdData),
    .accessErr(accessErr), .statusOut(statusOut), .timerIrq(timerIrq)
  );

  localparam logic [4:0] A_RAND = 5'd1, A_WIRED = 5'd6, A_COUNT = 5'd9,
                         A_CMP = 5'd11, A_STAT = 5'd12, A_CAUSE = 5'd13;

  // {regNum, write data, expected 32-bit read value, expected error}
  localparam int NV = 21;
  localparam logic [69:0] VECS [0:NV-1] = '{
    {5'd0,  32'hFFFF_FFFF, 32'h8000_003F, 1'b1},  // R2 index field 63
    {5'd0,  32'h1234_5A1F, 32'h0000_001F, 1'b0},  // R1
    {5'd2,  32'hFFFF_FFFF, 32'h3FFF_FFFF, 1'b0},  // R1
    {5'd3,  32'hC000_0001, 32'h0000_0001, 1'b0},  // R1
    {5'd5,  32'hFFFF_FFFF, 32'h01FF_E000, 1'b0},  // R1
    {5'd10, 32'hFFFF_FFFF, 32'hFFFF_E0FF, 1'b0},  // R1 R12 negative
    {5'd28, 32'hFFFF_FFFF, 32'h0FFF_FFC0, 1'b0},  // R1
    {5'd29, 32'hDEAD_BEEF, 32'h0000_0000, 1'b0},  // R5
    {5'd14, 32'h8000_1234, 32'h8000_1234, 1'b0},  // R1
    {5'd12, 32'h1234_5678, 32'h1234_5678, 1'b0},  // R1
    {5'd16, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0},  // R1
    {5'd18, 32'h0000_0F00, 32'h0000_0F00, 1'b0},  // R1
    {5'd19, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0},  // R1
    {5'd4,  32'hFFFF_FFFF, 32'hFF80_0000, 1'b0},  // R3
    {5'd8,  32'h1111_1111, 32'h0000_0000, 1'b0},  // R5
    {5'd15, 32'h0000_2222, 32'h0000_0000, 1'b0},  // R5
    {5'd1,  32'h0000_0003, 32'h0000_001F, 1'b0},  // R5
    {5'd7,  32'h0000_FFFF, 32'h0000_0000, 1'b1},  // R10
    {5'd31, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},  // R10
    {5'd13, 32'h0000_0005, 32'h0000_0000, 1'b1},  // R9
    {5'd6,  32'h0000_0005, 32'h0000_0005, 1'b0}   // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regNum = n; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n);
    regNum = n;
    #1;
  endtask

  task automatic pulse(input bit doTick, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      tickEn = doTick; retirePulse = !doTick;
      @(negedge clk);
      tickEn = 1'b0; retirePulse = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL R13 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    rd(A_RAND);  chk("R13 random", rdData, 64'd31);
    rd(A_COUNT); chk("R13 count", rdData, 64'd0);
    rd(5'd0);    chk("R13 index", rdData, 64'd0);
    chk("R13 status", {32'd0, statusOut}, 64'd0);
    chk("R13 irq", {63'd0, timerIrq}, 64'd0);
    chk("R13 err", {63'd0, accessErr}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      wr(VECS[v][69:65], VECS[v][64:33]);
      chk("R10 err flag", {63'd0, accessErr}, {63'd0, VECS[v][0]});
      rd(VECS[v][69:65]);
      chk("R12 read", rdData, {{32{VECS[v][32]}}, VECS[v][32:1]});
    end

    @(negedge clk);
    chk("R10 err one cycle", {63'd0, accessErr}, 64'd0);
    chk("R13 status out", {32'd0, statusOut}, 64'h1234_5678);
    rd(A_RAND); chk("R4 random after wired", rdData, 64'd31);
    rd(A_CAUSE); chk("R9 cause unchanged", rdData, 64'd0);

    // R11 random stepping
    wr(A_WIRED, 32'd28);
    rd(A_RAND); chk("R4 reload", rdData, 64'd31);
    pulse(1'b0, 3);
    rd(A_RAND); chk("R11 step down", rdData, 64'd28);
    pulse(1'b0, 1);
    rd(A_RAND); chk("R11 wrap at wired", rdData, 64'd31);
    wr(A_WIRED, 32'd0);
    pulse(1'b0, 1);
    rd(A_RAND); chk("R11 decrement", rdData, 64'd30);

    // R6/R7/R8 timer
    wr(A_COUNT, 32'd10);
    pulse(1'b1, 3);
    rd(A_COUNT); chk("R6 count ticks", rdData, 64'd13);
    wr(A_CMP, 32'd15);
    pulse(1'b1, 1);
    chk("R7 no early irq", {63'd0, timerIrq}, 64'd0);
    pulse(1'b1, 1);
    chk("R7 irq on match", {63'd0, timerIrq}, 64'd1);
    rd(A_CAUSE); chk("R7 cause bit15", rdData, 64'h0000_8000);
    pulse(1'b1, 1);
    chk("R7 irq held", {63'd0, timerIrq}, 64'd1);
    wr(A_CMP, 32'd100);
    chk("R8 compare clears", {63'd0, timerIrq}, 64'd0);
    rd(A_CMP); chk("R8 compare stored", rdData, 64'd100);
    wr(A_COUNT, 32'd99);
    pulse(1'b1, 1);
    chk("R7 irq after write+tick", {63'd0, timerIrq}, 64'd1);
    wr(A_CAUSE, 32'd0);
    chk("R9 cause zero clears", {63'd0, timerIrq}, 64'd0);
    chk("R9 zero write no err", {63'd0, accessErr}, 64'd0);
    wr(A_CMP, 32'd200);
    wr(A_COUNT, 32'd200);
    chk("R7 count write equal no irq", {63'd0, timerIrq}, 64'd0);

    // R6 write wins over tick
    @(negedge clk);
    wrEn = 1'b1; regNum = A_COUNT; wrData = 32'd500; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    rd(A_COUNT); chk("R6 write beats tick", rdData, 64'd500);
    wr(A_COUNT, 32'hFFFF_FFFF);
    rd(A_COUNT); chk("R12 count sign extend", rdData, 64'hFFFF_FFFF_FFFF_FFFF);
    pulse(1'b1, 1);
    rd(A_COUNT); chk("R6 count wraps", rdData, 64'd0);

    // R3 middle bits kept across a second write
    wr(5'd4, 32'h0000_0000);
    rd(5'd4); chk("R3 context rewrite", rdData, 64'd0);
    rd(A_STAT); chk("R12 status read", rdData, 64'h1234_5678);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule